// File: doc/BRIEF.md
# Buck Switching-Cycle Controller with Current Limits

This block is the digital cycle logic of a peak-current-mode synchronous buck stage. An internal period counter marks the start of every switching cycle. At that mark the block asks for the high-side switch. The high side stays on until the peak-current comparator trips, but never for less than a programmable minimum on-time. When the high side is off, the low side takes over. The two gate enables are separated by a fixed dead time.

The block also guards against current runaway. A short on the output can make the current grow from one cycle to the next once the minimum on-time clamps the duty cycle. To stop this, a valley comparator sampled at each cycle boundary can suppress the next high-side pulse, and keeps suppressing pulses while it stays set. A reverse-current comparator turns the low side off while it is asserted. A feedback-low flag stretches the switching period by a fixed factor, and the normal period returns once the flag clears. The comparators themselves are outside the block and arrive only as flags.

Top module: `buck_cycle_ctrl`

## Requirements
- R1: While `rst_n` is low, `hs_en` and `ls_en` are both 0.
- R2: When `cycle_start` is 1, `valley_over` is 0 and no high-side request is pending, a high-side request begins. `hs_en` then rises once the dead time has elapsed.
- R3: Once `hs_en` has been high for at least `min_on_cfg` cycles, `peak_hit` sampled high ends the pulse. `hs_en` is 0 in the following cycle.
- R4: Every `hs_en` pulse lasts at least `min_on_cfg` cycles, even when `peak_hit` arrives earlier.
- R5: If `valley_over` is 1 in a `cycle_start` cycle while no request is pending, that cycle gets no high-side pulse. Pulses stay suppressed at every cycle start that sees the flag set, and resume after it clears.
- R6: In the cycle after `reverse_over` is 1, `ls_en` is 0. It stays 0 while the flag is held.
- R7: With `fb_low` at 0, consecutive `cycle_start` pulses are exactly `period_cfg` cycles apart.
- R8: Each `cycle_start` chooses the length of the cycle it opens. That length is `FOLD_MULT` times `period_cfg` if `fb_low` is 1 in that cycle, and `period_cfg` otherwise, so the normal period returns by itself.
- R9: `hs_en` and `ls_en` are never 1 in the same cycle.
- R10: Before either enable rises, both enables have been 0 for at least `DEAD_CYC` consecutive cycles.
- R11: Once the high side is neither on nor requested, the dead time has elapsed and `reverse_over` is 0, `ls_en` rises. After a normal high-side pulse, this happens after exactly `DEAD_CYC` cycles with both enables off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_cfg | input | CNT_W | Normal switching period in clock cycles (at least 2) |
| min_on_cfg | input | CNT_W | Minimum high-side on-time in clock cycles (at least 1) |
| peak_hit | input | 1 | Sensed current has reached the control level |
| valley_over | input | 1 | Sensed current is above the valley limit |
| reverse_over | input | 1 | Reverse current is beyond its limit |
| fb_low | input | 1 | Feedback is below the foldback threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| cycle_start | output | 1 | One-cycle pulse marking the start of a switching cycle |

## Verification
The bench builds the block with an 8-bit count width, a dead time of 2 cycles and a fold factor of 4. It programs a 20-cycle period and a 4-cycle minimum on-time. A power-of-two fold factor selects the shift variant of the period stretch, and gives an 80-cycle folded period that two cycle starts can measure. With a 20-cycle period there is room for pulses both shorter and longer than the minimum on-time, for a full dead time on each side, and for a low-side stretch in which reverse cutoff can be applied. A behavioural inductor model with a fast rise and a slow decay makes the minimum on-time outpace the decay. This reaches the runaway condition that only valley skipping can stop.

// File: rtl/buck_ctrl_pkg.sv
package buck_ctrl_pkg;

  // High-side request sequencer states
  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_REQ  = 1'b1
  } hs_state_e;

  // Registered pair of gate enables
  typedef struct packed {
    logic hs;
    logic ls;
  } gate_pair_t;

endpackage

// File: rtl/buck_cycle_timer.sv
module buck_cycle_timer
  import buck_ctrl_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int FOLD_MULT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic             fb_low,
  output logic             tick
);

  localparam int FOLD_SH   = $clog2(FOLD_MULT);
  localparam int LEN_W     = CNT_W + FOLD_SH + 1;
  localparam bit FOLD_POW2 = (FOLD_MULT == (1 << FOLD_SH));

  logic [LEN_W-1:0] base_len;
  logic [LEN_W-1:0] fold_len;
  logic [LEN_W-1:0] sel_len;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] rem_d;

  assign base_len = LEN_W'(period_cfg);

  generate
    if (FOLD_POW2) begin : g_fold_shift
      assign fold_len = base_len << FOLD_SH;
    end else begin : g_fold_mult
      assign fold_len = base_len * LEN_W'(FOLD_MULT);
    end
  endgenerate

  // Length of the next cycle is fixed at its start
  assign sel_len = fb_low ? fold_len : base_len;
  assign tick    = (rem_q == '0);

  always_comb begin
    if (tick) begin
      rem_d = sel_len - LEN_W'(1);
    end else begin
      rem_d = rem_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else begin
      rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/buck_hs_sequencer.sv
module buck_hs_sequencer
  import buck_ctrl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             valley_over,
  input  logic             peak_hit,
  input  logic             hs_on,
  input  logic [CNT_W-1:0] min_on_cfg,
  output logic             hs_req
);

  hs_state_e        state_q;
  hs_state_e        state_d;
  logic [CNT_W-1:0] on_cnt_q;
  logic [CNT_W-1:0] on_cnt_d;
  logic             on_cnt_en;
  logic             min_met;
  logic             term;

  // Current cycle counts toward the minimum on-time
  assign min_met = ({1'b0, on_cnt_q} + (CNT_W+1)'(1)) >= {1'b0, min_on_cfg};
  assign term    = (state_q == HS_REQ) && hs_on && peak_hit && min_met;
  assign hs_req  = (state_q == HS_REQ) && !term;

  always_comb begin
    state_d   = state_q;
    on_cnt_d  = on_cnt_q;
    on_cnt_en = 1'b0;
    case (state_q)
      HS_IDLE: begin
        // Valley sampled at the cycle boundary decides the skip
        if (tick && !valley_over) begin
          state_d   = HS_REQ;
          on_cnt_d  = '0;
          on_cnt_en = 1'b1;
        end
      end
      HS_REQ: begin
        if (term) begin
          state_d = HS_IDLE;
        end else if (hs_on && (on_cnt_q != '1)) begin
          on_cnt_d  = on_cnt_q + CNT_W'(1);
          on_cnt_en = 1'b1;
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt_q <= '0;
    end else if (on_cnt_en) begin
      on_cnt_q <= on_cnt_d;
    end
  end

endmodule

// File: rtl/buck_gate_driver.sv
module buck_gate_driver
  import buck_ctrl_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_req,
  input  logic rev_cut,
  output logic hs_en,
  output logic ls_en
);

  localparam int GAP_W = $clog2(DEAD_CYC + 1);

  gate_pair_t       gate_q;
  gate_pair_t       gate_d;
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] gap_d;
  logic             gap_en;
  logic             gap_ok;

  assign gap_ok = (gap_q >= GAP_W'(DEAD_CYC - 1));

  always_comb begin
    gate_d = gate_q;
    gap_d  = gap_q;
    gap_en = 1'b0;
    if (gate_q.hs) begin
      if (!hs_req) begin
        gate_d.hs = 1'b0;
        gap_d     = '0;
        gap_en    = 1'b1;
      end
    end else if (gate_q.ls) begin
      if (hs_req || rev_cut) begin
        gate_d.ls = 1'b0;
        gap_d     = '0;
        gap_en    = 1'b1;
      end
    end else begin
      // Both off: count dead time, then hand over
      if (gap_q != GAP_W'(DEAD_CYC)) begin
        gap_d  = gap_q + GAP_W'(1);
        gap_en = 1'b1;
      end
      if (gap_ok) begin
        if (hs_req) begin
          gate_d.hs = 1'b1;
        end else if (!rev_cut) begin
          gate_d.ls = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
    end else begin
      gate_q <= gate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (gap_en) begin
      gap_q <= gap_d;
    end
  end

  assign hs_en = gate_q.hs;
  assign ls_en = gate_q.ls;

endmodule

// File: rtl/buck_cycle_ctrl.sv
module buck_cycle_ctrl
  import buck_ctrl_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int FOLD_MULT = 4,
  parameter int DEAD_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic [CNT_W-1:0] min_on_cfg,
  input  logic             peak_hit,
  input  logic             valley_over,
  input  logic             reverse_over,
  input  logic             fb_low,
  output logic             hs_en,
  output logic             ls_en,
  output logic             cycle_start
);

  logic tick;
  logic hs_req;

  buck_cycle_timer #(
    .CNT_W     (CNT_W),
    .FOLD_MULT (FOLD_MULT)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_cfg (period_cfg),
    .fb_low     (fb_low),
    .tick       (tick)
  );

  buck_hs_sequencer #(
    .CNT_W (CNT_W)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .valley_over (valley_over),
    .peak_hit    (peak_hit),
    .hs_on       (hs_en),
    .min_on_cfg  (min_on_cfg),
    .hs_req      (hs_req)
  );

  buck_gate_driver #(
    .DEAD_CYC (DEAD_CYC)
  ) gate_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_req  (hs_req),
    .rev_cut (reverse_over),
    .hs_en   (hs_en),
    .ls_en   (ls_en)
  );

  assign cycle_start = tick;

endmodule

// File: rtl/buck_cycle_ctrl_sva.sv
module buck_cycle_ctrl_sva #(
  parameter int CNT_W     = 8,
  parameter int FOLD_MULT = 4,
  parameter int DEAD_CYC  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] period_cfg,
  input logic [CNT_W-1:0] min_on_cfg,
  input logic             peak_hit,
  input logic             valley_over,
  input logic             reverse_over,
  input logic             fb_low,
  input logic             hs_en,
  input logic             ls_en,
  input logic             cycle_start,
  input logic             hs_req
);

  logic [15:0] hs_run;
  logic [15:0] off_run;
  logic [15:0] since;
  logic [15:0] exp_len;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_run  <= '0;
      off_run <= '0;
      since   <= '0;
      exp_len <= '0;
      seen    <= 1'b0;
    end else begin
      hs_run  <= hs_en ? ((hs_run == 16'hFFFF) ? hs_run : hs_run + 16'd1) : 16'd0;
      off_run <= (!hs_en && !ls_en) ?
                 ((off_run == 16'hFFFF) ? off_run : off_run + 16'd1) : 16'd0;
      if (cycle_start) begin
        since   <= '0;
        seen    <= 1'b1;
        exp_len <= fb_low ? (16'(period_cfg) * 16'(FOLD_MULT)) : 16'(period_cfg);
      end else if (since != 16'hFFFF) begin
        since <= since + 16'd1;
      end
    end
  end

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  assert_min_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_en) |-> (hs_run >= 16'(min_on_cfg)));

  assert_peak_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en && peak_hit && ((hs_run + 16'd1) >= 16'(min_on_cfg))) |=> !hs_en);

  assert_valley_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && valley_over && !hs_req) |=> !hs_req);

  assert_start_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && !valley_over && !hs_req && !hs_en) |=> hs_req);

  assert_rev_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reverse_over |=> !ls_en);

  assert_period_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_start && seen) |-> ((since + 16'd1) == exp_len));

  assert_dead_time_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_en) || $rose(ls_en)) |-> (off_run >= 16'(DEAD_CYC)));

  assert_ls_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_en && !ls_en && !hs_req && !reverse_over &&
     (off_run >= 16'(DEAD_CYC - 1))) |=> ls_en);

endmodule

bind buck_cycle_ctrl buck_cycle_ctrl_sva #(
  .CNT_W     (CNT_W),
  .FOLD_MULT (FOLD_MULT),
  .DEAD_CYC  (DEAD_CYC)
) sva_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .period_cfg   (period_cfg),
  .min_on_cfg   (min_on_cfg),
  .peak_hit     (peak_hit),
  .valley_over  (valley_over),
  .reverse_over (reverse_over),
  .fb_low       (fb_low),
  .hs_en        (hs_en),
  .ls_en        (ls_en),
  .cycle_start  (cycle_start),
  .hs_req       (hs_req)
);

// File: tb/buck_cycle_ctrl_tb_top.sv
module buck_cycle_ctrl_tb_top;

  localparam int CNT_W     = 8;
  localparam int FOLD_MULT = 4;
  localparam int DEAD_CYC  = 2;
  localparam int PER       = 20;
  localparam int MINON     = 4;
  localparam int I_UP      = 10;
  localparam int I_PEAK    = 60;
  localparam int I_VALLEY  = 40;
  localparam int I_REV     = 30;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [CNT_W-1:0] period_cfg;
  logic [CNT_W-1:0] min_on_cfg;
  logic             peak_hit, valley_over, reverse_over, fb_low;
  logic             hs_en, ls_en, cycle_start;

  bit   model_on   = 1'b0;
  bit   man_valley = 1'b0;
  bit   man_rev    = 1'b0;
  bit   man_fb     = 1'b0;
  logic man_peak   = 1'b0;
  int   peak_after = MINON;

  int ind_i = 0, imax = 0;
  int hs_cur = 0, last_hs_w = 0, hs_pulses = 0, hs_rises = 0;
  int off_cur = 0, last_ls_gap = -1, overlap_n = 0, dt_viol = 0;
  int since = 0, last_int = 0, ticks = 0, valley_ticks = 0;
  bit hs_prev = 1'b0, ls_prev = 1'b0;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  assign peak_hit     = model_on ? (ind_i >= I_PEAK)   : man_peak;
  assign valley_over  = model_on ? (ind_i >= I_VALLEY) : man_valley;
  assign reverse_over = model_on ? (ind_i <= -I_REV)   : man_rev;
  assign fb_low       = man_fb;

  buck_cycle_ctrl #(
    .CNT_W     (CNT_W),
    .FOLD_MULT (FOLD_MULT),
    .DEAD_CYC  (DEAD_CYC)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_cfg   (period_cfg),
    .min_on_cfg   (min_on_cfg),
    .peak_hit     (peak_hit),
    .valley_over  (valley_over),
    .reverse_over (reverse_over),
    .fb_low       (fb_low),
    .hs_en        (hs_en),
    .ls_en        (ls_en),
    .cycle_start  (cycle_start)
  );

  // Monitor and behavioural current model, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      ind_i = 0; imax = 0; hs_cur = 0; off_cur = 0; since = 0;
      hs_prev = 1'b0; ls_prev = 1'b0; man_peak = 1'b0;
    end else begin
      if (hs_en && ls_en) overlap_n++;
      if (hs_en && !hs_prev) begin
        hs_rises++;
        if (off_cur < DEAD_CYC) dt_viol++;
      end
      if (ls_en && !ls_prev) begin
        last_ls_gap = off_cur;
        if (off_cur < DEAD_CYC) dt_viol++;
      end
      if (!hs_en && !ls_en) off_cur++; else off_cur = 0;
      if (hs_en) begin
        hs_cur++;
      end else if (hs_prev) begin
        last_hs_w = hs_cur;
        hs_pulses++;
        hs_cur = 0;
      end
      if (cycle_start) begin
        last_int = since + 1;
        since = 0;
        ticks++;
        if (valley_over) valley_ticks++;
      end else begin
        since++;
      end
      if (model_on) begin
        if (hs_en) ind_i += I_UP;
        else if (ls_en) ind_i -= 1;
        else if (ind_i > 0) ind_i -= 1;
        if (ind_i > imax) imax = ind_i;
      end
      man_peak = hs_en && (hs_cur >= peak_after);
      hs_prev = hs_en;
      ls_prev = ls_en;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pulses(input int n);
    int s = hs_pulses;
    for (int k = 0; k < 2000 && hs_pulses < s + n; k++) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    int s = ticks;
    for (int k = 0; k < 2000 && ticks < s + n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    int bad = 0;
    rst_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (hs_en || ls_en) bad++;
    end
    chk(bad == 0, "R1 enables low in reset", bad, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_start;
    int r0 = hs_rises;
    wait_cyc(10);
    chk(hs_rises > r0, "R2 high side starts after cycle start", hs_rises - r0, 1);
  endtask

  task automatic t_pulse_width;
    peak_after = 1;
    wait_pulses(2);
    chk(last_hs_w == MINON, "R4 early peak held to min on-time", last_hs_w, MINON);
    peak_after = 7;
    wait_pulses(2);
    chk(last_hs_w == 7, "R3 late peak ends pulse", last_hs_w, 7);
    peak_after = MINON;
    wait_pulses(2);
    chk(last_hs_w == MINON, "R3 peak at min on-time", last_hs_w, MINON);
    wait_cyc(DEAD_CYC + 2);
    chk(last_ls_gap == DEAD_CYC, "R11 low side after dead time", last_ls_gap, DEAD_CYC);
  endtask

  task automatic t_period;
    wait_ticks(2);
    chk(last_int == PER, "R7 normal period", last_int, PER);
  endtask

  task automatic t_fold;
    man_fb = 1'b1;
    wait_ticks(2);
    chk(last_int == PER * FOLD_MULT, "R8 folded period", last_int, PER * FOLD_MULT);
    man_fb = 1'b0;
    wait_ticks(2);
    chk(last_int == PER, "R8 period recovers", last_int, PER);
  endtask

  task automatic t_skip;
    int r0;
    wait_pulses(1);
    man_valley = 1'b1;
    r0 = hs_rises;
    wait_cyc(3 * PER);
    chk(hs_rises == r0, "R5 pulses skipped while valley set", hs_rises - r0, 0);
    man_valley = 1'b0;
    wait_cyc(PER + DEAD_CYC + 4);
    chk(hs_rises > r0, "R5 pulses resume after valley clears", hs_rises - r0, 1);
  endtask

  task automatic t_reverse;
    int on_n = 0;
    for (int k = 0; k < 100 && !ls_en; k++) @(negedge clk);
    man_rev = 1'b1;
    @(negedge clk);
    chk(!ls_en, "R6 low side cut next cycle", int'(ls_en), 0);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (ls_en) on_n++;
    end
    chk(on_n == 0, "R6 low side held off", on_n, 0);
    man_rev = 1'b0;
    on_n = 0;
    for (int k = 0; k < PER + 4; k++) begin
      @(negedge clk);
      if (ls_en) on_n++;
    end
    chk(on_n > 0, "R11 low side returns after reverse clears", on_n, 1);
  endtask

  task automatic t_model;
    int v0 = valley_ticks;
    int r0 = hs_rises;
    model_on = 1'b1;
    wait_cyc(3000);
    model_on = 1'b0;
    chk(overlap_n == 0, "R9 no overlap", overlap_n, 0);
    chk(dt_viol == 0, "R10 dead time kept", dt_viol, 0);
    chk(imax <= I_VALLEY + I_UP * MINON, "R5 no current runaway", imax, I_VALLEY + I_UP * MINON);
    chk(valley_ticks > v0, "R5 valley skips occurred", valley_ticks - v0, 1);
    chk(hs_rises > r0, "R2 switching under model", hs_rises - r0, 1);
  endtask

  initial begin
    rst_n      = 1'b0;
    period_cfg = CNT_W'(PER);
    min_on_cfg = CNT_W'(MINON);
    t_reset();
    t_start();
    t_pulse_width();
    t_period();
    t_fold();
    t_skip();
    t_reverse();
    t_model();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule